// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Interface

This block sits between an 8-bit asynchronous CPU bus and a small bank of eight internal registers. The CPU side carries three address lines, an active-low select, active-low read and write strobes, an 8-bit data bus with separate input and output halves, and a static strap that picks the access style. All bus pins are brought into the core clock through two-flop synchronizers. The block then turns each access into clean single-cycle events for the register bank: a write pulse with its address and data, and a read enable with a held read address, a read-end pulse, and a drive enable for the external tri-state data buffer.

The strap selects between two access styles. With the strap high, separate read and write strobes mark each access while select is low. With the strap low, the read strobe is not used. The level of the write line at the moment select falls fixes the direction of the whole access. The access ends when select rises.

Top module: `hbus_host_if`

## Requirements
- R1: While reset is asserted and right after it, `bus_oe`, `reg_rd_en`, `reg_rd_pulse` and `reg_wr_pulse` are all 0.
- R2: With `mode_dual`=1 and `bus_cs_n`=0, a low `bus_rd_n` starts a read. `reg_rd_en` rises three core clock edges after the strobe falls. `bus_oe` rises one edge later, and `bus_dout` then shows `reg_rdata` for the address on `bus_addr`.
- R3: With `mode_dual`=1 and `bus_cs_n`=0, a low `bus_wr_n` writes. Exactly one `reg_wr_pulse` of one cycle appears three edges after the strobe (or select) rises. `reg_wr_addr` and `reg_wr_data` carry the address and data seen while the strobe was low. Data bit 0 is the least significant bit.
- R4: While `bus_cs_n`=1, activity on `bus_rd_n` and `bus_wr_n` starts no access: no write pulse, no read enable and no bus drive.
- R5: With `mode_dual`=0, `bus_rd_n` is ignored. A low `bus_wr_n` at the falling edge of `bus_cs_n` makes the access a write, committed by one pulse when `bus_cs_n` rises. A high level makes it a read, driven from the fourth edge after select falls.
- R6: With `mode_dual`=0, the direction fixed at select fall holds for the whole access. Toggling `bus_wr_n` during a read access produces no write pulse and does not end the read.
- R7: While `bus_oe`=1, `bus_dout` stays constant even when `reg_rdata` changes.
- R8: When a read access ends, `bus_oe` and `reg_rd_en` fall and `reg_rd_pulse` is high for exactly one cycle, with `reg_rd_addr` still holding the read address. Write accesses produce no read pulse.
- R9: With `mode_dual`=1, a write strobe rising together with a read strobe falling yields both the write pulse and the read start on the same core clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_dual | input | 1 | Static strap: 1 = separate read/write strobes, 0 = single strobe with direction taken from the write line |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rd_n | input | 1 | Active-low read strobe (dual mode only) |
| bus_wr_n | input | 1 | Active-low write strobe, or direction line in single-strobe mode |
| bus_addr | input | 3 | Register address |
| bus_din | input | 8 | Data bus input half |
| bus_dout | output | 8 | Held read data for the data bus |
| bus_oe | output | 1 | Data bus drive enable |
| reg_rdata | input | 8 | Read data from the register bank for `reg_rd_addr` |
| reg_rd_en | output | 1 | Read access in progress |
| reg_rd_addr | output | 3 | Address of the current or last read |
| reg_rd_pulse | output | 1 | One-cycle pulse at the end of a read access |
| reg_wr_pulse | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 3 | Write address, valid with the pulse |
| reg_wr_data | output | 8 | Write data, valid with the pulse |

## Verification
The end of a write and the start of a read can land on the same core clock edge when the CPU releases the write strobe and asserts the read strobe in one bus step. The bench provokes this with both pin changes in the same half cycle. It then requires the write pulse and the read enable to be high on the same sampled cycle. The scoreboard must still pop the write with its data, and the later read must drive the right register value.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  localparam int unsigned HB_AW = 3;
  localparam int unsigned HB_DW = 8;

  // Select and strobe both active (both pins low)
  function automatic logic f_both_low(input logic sel_n, input logic strobe_n);
    return ~sel_n & ~strobe_n;
  endfunction

  // Falling edge between a previous and current sample
  function automatic logic f_fell(input logic now_v, input logic prev_v);
    return prev_v & ~now_v;
  endfunction

  // Single-strobe mode: write line low at select fall means write
  function automatic logic f_dir_is_write(input logic wr_n_v);
    return ~wr_n_v;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_V;
          else        chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_V;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hbus_track.sv
module hbus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_dual,
  input  logic lvl_dual,
  input  logic cs_fall,
  input  logic cs_n_s,
  input  logic dir_match,
  output logic act_o,
  output logic start_o,
  output logic stop_o
);

  logic act_q;

  always_comb begin
    if (mode_dual) begin
      start_o = lvl_dual & ~act_q;
      stop_o  = act_q & ~lvl_dual;
    end else begin
      start_o = cs_fall & dir_match & ~act_q;
      stop_o  = act_q & cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= 1'b0;
    else if (start_o) act_q <= 1'b1;
    else if (stop_o)  act_q <= 1'b0;
  end

  assign act_o = act_q;

endmodule

// File: rtl/hbus_wr_cap.sv
module hbus_wr_cap #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          act_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          pulse_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  logic          capture;
  logic          pulse_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign capture = start_i | (act_i & ~stop_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      pulse_q <= stop_i;
      if (capture) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign pulse_o = pulse_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R3

endmodule

// File: rtl/hbus_rd_hold.sv
module hbus_rd_hold #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] dout_o,
  output logic          oe_o,
  output logic          rd_pulse_o
);

  logic          ld_q;
  logic          oe_q;
  logic          pulse_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q    <= 1'b0;
      oe_q    <= 1'b0;
      pulse_q <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
    end else begin
      pulse_q <= stop_i;
      if (stop_i) begin
        ld_q <= 1'b0;
        oe_q <= 1'b0;
      end else if (start_i) begin
        addr_q <= addr_i;
        ld_q   <= 1'b1;
      end else if (ld_q) begin
        dout_q <= rdata_i;
        oe_q   <= 1'b1;
        ld_q   <= 1'b0;
      end
    end
  end

  assign rd_addr_o  = addr_q;
  assign dout_o     = dout_q;
  assign oe_o       = oe_q;
  assign rd_pulse_o = pulse_q;

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && $past(oe_q)) |-> $stable(dout_q)); // R7

endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
  import hbus_pkg::*;
#(
  parameter int unsigned AW          = HB_AW,
  parameter int unsigned DW          = HB_DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_dual,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_rd_en,
  output logic [AW-1:0] reg_rd_addr,
  output logic          reg_rd_pulse,
  output logic          reg_wr_pulse,
  output logic [AW-1:0] reg_wr_addr,
  output logic [DW-1:0] reg_wr_data
);

  localparam int unsigned SW = 4 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b1, 1'b1, {AW{1'b0}}, {DW{1'b0}}};

  logic [SW-1:0] raw_vec;
  logic [SW-1:0] sync_vec;
  logic          mode_s, cs_n_s, rd_n_s, wr_n_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          cs_prev_q;

  // Named internal events for checking
  logic cs_fall;
  logic wr_lvl, rd_lvl;
  logic wr_act, wr_start, wr_stop;
  logic rd_act, rd_start, rd_stop;

  assign raw_vec = {mode_dual, bus_cs_n, bus_rd_n, bus_wr_n, bus_addr, bus_din};

  hbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_V(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  assign {mode_s, cs_n_s, rd_n_s, wr_n_s, addr_s, data_s} = sync_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prev_q <= 1'b1;
    else        cs_prev_q <= cs_n_s;
  end

  assign cs_fall = f_fell(cs_n_s, cs_prev_q);
  assign wr_lvl  = f_both_low(cs_n_s, wr_n_s);
  assign rd_lvl  = f_both_low(cs_n_s, rd_n_s);

  hbus_track u_wr_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dual (mode_s),
    .lvl_dual  (wr_lvl),
    .cs_fall   (cs_fall),
    .cs_n_s    (cs_n_s),
    .dir_match (f_dir_is_write(wr_n_s)),
    .act_o     (wr_act),
    .start_o   (wr_start),
    .stop_o    (wr_stop)
  );

  hbus_track u_rd_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dual (mode_s),
    .lvl_dual  (rd_lvl),
    .cs_fall   (cs_fall),
    .cs_n_s    (cs_n_s),
    .dir_match (~f_dir_is_write(wr_n_s)),
    .act_o     (rd_act),
    .start_o   (rd_start),
    .stop_o    (rd_stop)
  );

  hbus_wr_cap #(.AW(AW), .DW(DW)) u_wr_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wr_start),
    .stop_i  (wr_stop),
    .act_i   (wr_act),
    .addr_i  (addr_s),
    .data_i  (data_s),
    .pulse_o (reg_wr_pulse),
    .addr_o  (reg_wr_addr),
    .data_o  (reg_wr_data)
  );

  hbus_rd_hold #(.AW(AW), .DW(DW)) u_rd_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (rd_start),
    .stop_i     (rd_stop),
    .addr_i     (addr_s),
    .rdata_i    (reg_rdata),
    .rd_addr_o  (reg_rd_addr),
    .dout_o     (bus_dout),
    .oe_o       (bus_oe),
    .rd_pulse_o (reg_rd_pulse)
  );

  assign reg_rd_en = rd_act;

  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> reg_rd_en); // R2

  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> (!bus_oe && !reg_rd_en)); // R4

  AST_RD_PULSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_pulse |-> (!reg_rd_en && $past(reg_rd_en))); // R8

  AST_SINGLE_NO_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && $past(!mode_s)) |-> !(wr_act && rd_act)); // R6

endmodule

// File: tb/test_hbus_host_if.sv
`timescale 1ns/1ps
module test_hbus_host_if;

  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam int unsigned WATCHDOG_CYC = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_dual = 1'b1;
  logic          bus_cs_n = 1'b1;
  logic          bus_rd_n = 1'b1;
  logic          bus_wr_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] bus_dout;
  logic          bus_oe;
  logic [DW-1:0] reg_rdata;
  logic          reg_rd_en;
  logic [AW-1:0] reg_rd_addr;
  logic          reg_rd_pulse;
  logic          reg_wr_pulse;
  logic [AW-1:0] reg_wr_addr;
  logic [DW-1:0] reg_wr_data;
  logic [DW-1:0] perturb = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [AW+DW-1:0] wr_q [$];
  logic [AW-1:0]    rd_q [$];

  always #2.5 clk = ~clk;

  // Bench register bank model: value depends on address, perturb models clear-on-read
  function automatic logic [DW-1:0] bank_val(input logic [AW-1:0] a);
    return 8'h3C + {a, 5'b0} + {5'b0, a};
  endfunction

  assign reg_rdata = bank_val(reg_rd_addr) ^ perturb;

  hbus_host_if i_hbus_host_if (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_dual    (mode_dual),
    .bus_cs_n     (bus_cs_n),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_addr     (bus_addr),
    .bus_din      (bus_din),
    .bus_dout     (bus_dout),
    .bus_oe       (bus_oe),
    .reg_rdata    (reg_rdata),
    .reg_rd_en    (reg_rd_en),
    .reg_rd_addr  (reg_rd_addr),
    .reg_rd_pulse (reg_rd_pulse),
    .reg_wr_pulse (reg_wr_pulse),
    .reg_wr_addr  (reg_wr_addr),
    .reg_wr_data  (reg_wr_data)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_wr_pulse) begin
        if (wr_q.size() == 0) check("R3", "unexpected write pulse", {5'b0, reg_wr_addr, reg_wr_data}, 16'hFFFF);
        else begin
          logic [AW+DW-1:0] e;
          e = wr_q.pop_front();
          check("R3", "write addr/data", {5'b0, reg_wr_addr, reg_wr_data}, {5'b0, e});
        end
      end
      if (reg_rd_pulse) begin
        if (rd_q.size() == 0) check("R8", "unexpected read pulse", {13'b0, reg_rd_addr}, 16'hFFFF);
        else begin
          logic [AW-1:0] ea;
          ea = rd_q.pop_front();
          check("R8", "read pulse addr", {13'b0, reg_rd_addr}, {13'b0, ea});
          check("R8", "rd_en low at pulse", {15'b0, reg_rd_en}, 16'h0);
        end
      end
    end
  end

  task automatic dual_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_din = d; bus_cs_n = 1'b0;
    step(1);
    bus_wr_n = 1'b0;
    step(3);
    bus_wr_n = 1'b1;
    wr_q.push_back({a, d});
    step(3);
    check("R3", "pulse 3 edges after strobe rise", {15'b0, reg_wr_pulse}, 16'h1);
    bus_cs_n = 1'b1;
    step(4);
  endtask

  task automatic dual_read(input logic [AW-1:0] a);
    bus_addr = a; bus_cs_n = 1'b0;
    step(1);
    bus_rd_n = 1'b0;
    step(3);
    check("R2", "rd_en after 3 edges", {15'b0, reg_rd_en}, 16'h1);
    check("R2", "oe not yet", {15'b0, bus_oe}, 16'h0);
    step(1);
    check("R2", "oe driven", {15'b0, bus_oe}, 16'h1);
    check("R2", "read data", {8'b0, bus_dout}, {8'b0, bank_val(a)});
    perturb = 8'hFF;
    step(2);
    check("R7", "dout held", {8'b0, bus_dout}, {8'b0, bank_val(a)});
    perturb = 8'h00;
    bus_rd_n = 1'b1;
    rd_q.push_back(a);
    step(4);
    check("R8", "oe off after read", {15'b0, bus_oe}, 16'h0);
    bus_cs_n = 1'b1;
    step(4);
  endtask

  task automatic single_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_din = d; bus_wr_n = 1'b0;
    step(1);
    bus_cs_n = 1'b0;
    step(2);
    bus_rd_n = 1'b0;   // R5: read strobe ignored in single mode
    step(3);
    check("R5", "no read during single write", {15'b0, reg_rd_en | bus_oe}, 16'h0);
    bus_rd_n = 1'b1;
    bus_cs_n = 1'b1;
    wr_q.push_back({a, d});
    step(1);
    bus_wr_n = 1'b1;
    step(5);
  endtask

  task automatic single_read(input logic [AW-1:0] a);
    bus_addr = a; bus_wr_n = 1'b1;
    step(1);
    bus_cs_n = 1'b0;
    step(4);
    check("R5", "single read oe", {15'b0, bus_oe}, 16'h1);
    check("R5", "single read data", {8'b0, bus_dout}, {8'b0, bank_val(a)});
    bus_wr_n = 1'b0;   // R6: direction fixed, no write may result
    step(3);
    bus_wr_n = 1'b1;
    step(1);
    check("R6", "read still active", {15'b0, bus_oe}, 16'h1);
    bus_cs_n = 1'b1;
    rd_q.push_back(a);
    step(3);
    check("R8", "single read ended", {15'b0, bus_oe | reg_rd_en}, 16'h0);
    step(3);
  endtask

  initial begin
    step(3);
    check("R1", "outputs in reset", {12'b0, bus_oe, reg_rd_en, reg_rd_pulse, reg_wr_pulse}, 16'h0);
    rst_n = 1'b1;
    step(4);
    check("R1", "outputs after reset", {12'b0, bus_oe, reg_rd_en, reg_rd_pulse, reg_wr_pulse}, 16'h0);

    // Dual-strobe mode
    dual_write(3'd5, 8'hA5);
    dual_write(3'd0, 8'h01);   // bit 0 is LSB
    dual_write(3'd7, 8'h80);
    dual_read(3'd2);
    dual_read(3'd7);

    // R4: strobes while deselected
    for (int i = 0; i < 3; i++) begin
      bus_rd_n = 1'b0; bus_wr_n = 1'b0;
      step(2);
      bus_rd_n = 1'b1; bus_wr_n = 1'b1;
      step(2);
    end
    step(3);
    check("R4", "no access deselected", {14'b0, bus_oe, reg_rd_en}, 16'h0);

    // R9: write end and read start in the same bus step
    bus_addr = 3'd4; bus_din = 8'h3E; bus_cs_n = 1'b0;
    step(1);
    bus_wr_n = 1'b0;
    step(3);
    bus_wr_n = 1'b1; bus_rd_n = 1'b0;
    wr_q.push_back({3'd4, 8'h3E});
    step(3);
    check("R9", "wr pulse with rd_en same cycle", {14'b0, reg_wr_pulse, reg_rd_en}, 16'h3);
    step(2);
    check("R9", "read data after coincident start", {8'b0, bus_dout}, {8'b0, bank_val(3'd4)});
    bus_rd_n = 1'b1;
    rd_q.push_back(3'd4);
    step(3);
    bus_cs_n = 1'b1;
    step(4);

    // Single-strobe mode
    mode_dual = 1'b0;
    step(5);
    single_write(3'd1, 8'h5C);
    single_read(3'd6);
    single_write(3'd6, 8'hC3);
    single_read(3'd1);

    step(6);
    check("R3", "write scoreboard drained", 16'(wr_q.size()), 16'h0);
    check("R8", "read scoreboard drained", 16'(rd_q.size()), 16'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule